// File: doc/BRIEF.md
# Grouped Frame Power-Gating Controller

This block holds the power-control register of a set of per-core interrupt-controller frames that share a single power group. Each frame has one 32-bit power register. Software writes it to ask for that frame to be powered up or down, and reads it to learn the frame's effective state and the state of the shared group. The group is powered down only when the last powered frame is released. It is powered up again as soon as any frame asks for power. Both group transitions take a programmable number of cycles.

While a group transition runs, software sees the group target bit and the group status bit disagree. When they agree again, the group is stable. A transition can be aborted by an external abort input. A power-down can also be aborted by a frame power-on request that arrives during it. After an abort the two bits settle to equal values that describe the state the group actually holds. Writes that arrive during a transition are stored at once and take effect when the group is next stable on.

A group sequencer state machine has six states:
- `GRP_OFF`: stable off.
- `GRP_PWRUP`: powering up.
- `GRP_ON`: stable on, and frame requests are applied.
- `GRP_PWRDN`: powering down.
- `GRP_DN_ABORT`: settling after an aborted power-down.
- `GRP_UP_ABORT`: settling after an aborted power-up.

Its transitions are:
- off→pwrup on any frame request.
- pwrup→on when the up count expires.
- pwrup→up_abort on abort.
- up_abort→off.
- on→pwrdn when no frame requests power.
- pwrdn→off when the down count expires.
- pwrdn→dn_abort on abort or on a new frame request.
- dn_abort→on.

Top module: `grp_pwr_gate_ctrl`

## Requirements
- R1: After reset every frame's power register reads 0x0000000D: bit 0 = 1, bit 1 = 0, bit 2 = 1, bit 3 = 1. `frame_pwr_o` is all zero.
- R2: The power register lives at byte offset 0x24 of the selected frame. A read at any other offset returns 0, and a write at any other offset changes nothing.
- R3: Bit 1 is a stored mode bit that reads back as written. A write with bit 1 = 1 leaves the frame's power request unchanged. A write with bit 1 = 0 requests power-off when bit 0 = 1 and power-on when bit 0 = 0.
- R4: Bit 2 is the group target (1 = off) and bit 3 is the group's present off state. The group is stable exactly when the two bits are equal: 1/1 when off, 0/0 when on.
- R5: Suppose a power-on write is accepted at clock edge E while the group is off. Then bit 2 reads 0 and bit 3 reads 1 after edge E+1. Bit 3 clears after edge E+UP_CYCLES+1. The frame's bit 0 reads 0 only after edge E+UP_CYCLES+2.
- R6: Suppose a power-off write for the last powered frame is accepted at edge E. Then that frame's bit 0 and bit 2 read 1 after edge E+1, and bit 3 reads 1 after edge E+DN_CYCLES+1.
- R7: A power-off write for a frame that is not the last powered frame sets its bit 0 after one further edge, and the group bits stay 0/0.
- R8: A power-on write accepted during a group power-down aborts it. The group bits read 0/0 one edge later, bit 3 never reads 1, and the frame's bit 0 reads 0 three edges after the write edge.
- R9: An abort input sampled during a transition makes the group bits equal on the next edge: 0/0 for an aborted power-down, 1/1 for an aborted power-up. A power-up aborted while frames still request power restarts two edges later.
- R10: Writes accepted during a transition are held, not dropped, and are applied once the group is stable on. Frame power outputs change only after a stable-on cycle.
- R11: `frame_pwr_o[i]` is the inverse of frame i's bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Register access valid |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_frame | input | FRAME_IDX_W | Frame index of the access |
| acc_offset | input | 12 | Byte offset within the frame |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data (combinational, zero unless a read hits the power register) |
| grp_abort | input | 1 | Abort the group transition in progress |
| frame_pwr_o | output | NUM_FRAMES | Effective power state per frame, 1 = powered |

## Verification
The bench counts edges from each write to the moment bit 3 and bit 0 change. A sequencer whose counter is off by one, or that uses the wrong count for a direction, shows up as a wrong edge number. Releasing the last frame and releasing a non-last frame are tested apart. A design that got last-frame detection wrong would either power the group down early or never power it down.

Both abort paths are driven at known states, with the status bits read on each of the following edges. A design that leaves the bits unequal, or reports the wrong settled state, fails there. Writes issued mid power-up, one to power a second frame on and one to release the first, must both take effect afterwards. A design that dropped or applied them early would show the wrong frame outputs.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

    typedef enum logic [2:0] {
        GRP_OFF      = 3'd0,
        GRP_PWRUP    = 3'd1,
        GRP_ON       = 3'd2,
        GRP_PWRDN    = 3'd3,
        GRP_DN_ABORT = 3'd4,
        GRP_UP_ABORT = 3'd5
    } grp_state_t;

    localparam logic [11:0] PWR_REG_OFS = 12'h024;
    localparam int DATA_W = 32;

    localparam int B_FRM_OFF  = 0;
    localparam int B_MODE     = 1;
    localparam int B_GRP_TGT  = 2;
    localparam int B_GRP_OFF  = 3;

endpackage

// File: rtl/gpc_acc_dec.sv
module gpc_acc_dec #(
    parameter int NUM_FRAMES  = 4,
    parameter int FRAME_IDX_W = 2
) (
    input  logic                   acc_en,
    input  logic                   acc_wr,
    input  logic [FRAME_IDX_W-1:0] acc_frame,
    input  logic [11:0]            acc_offset,
    output logic [NUM_FRAMES-1:0]  wr_stb,
    output logic                   rd_hit
);
    import gpc_pkg::*;

    logic reg_hit;
    logic frame_ok;

    assign reg_hit  = acc_en && (acc_offset == PWR_REG_OFS);
    assign frame_ok = (32'(acc_frame) < NUM_FRAMES);
    assign rd_hit   = reg_hit && !acc_wr && frame_ok;

    for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_stb
        assign wr_stb[i] = reg_hit && acc_wr && (32'(acc_frame) == i);
    end

endmodule

// File: rtl/gpc_frame_bank.sv
module gpc_frame_bank #(
    parameter int NUM_FRAMES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FRAMES-1:0] wr_stb,
    input  logic [31:0]           wdata,
    input  logic                  apply,
    output logic [NUM_FRAMES-1:0] want_on,
    output logic [NUM_FRAMES-1:0] mode,
    output logic [NUM_FRAMES-1:0] frame_on
);
    import gpc_pkg::*;

    for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_frm
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                want_on[i] <= 1'b0;
                mode[i]    <= 1'b0;
            end else if (wr_stb[i]) begin
                mode[i] <= wdata[B_MODE];
                if (!wdata[B_MODE]) begin
                    want_on[i] <= !wdata[B_FRM_OFF];
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                frame_on[i] <= 1'b0;
            end else if (apply) begin
                frame_on[i] <= want_on[i];
            end
        end
    end

endmodule

// File: rtl/gpc_grp_seq.sv
module gpc_grp_seq #(
    parameter int NUM_FRAMES = 4,
    parameter int UP_CYCLES  = 8,
    parameter int DN_CYCLES  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FRAMES-1:0] want_on,
    input  logic                  abort_i,
    output logic                  grp_req_off,
    output logic                  grp_off,
    output logic                  apply_o
);
    import gpc_pkg::*;

    localparam int MAX_CYC = (UP_CYCLES > DN_CYCLES) ? UP_CYCLES : DN_CYCLES;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC + 1) : 1;
    localparam logic [CNT_W-1:0] UP_LAST = CNT_W'(UP_CYCLES - 1);
    localparam logic [CNT_W-1:0] DN_LAST = CNT_W'(DN_CYCLES - 1);

    grp_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic            any_req;

    assign any_req = |want_on;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GRP_OFF:      if (any_req) state_d = GRP_PWRUP;
            GRP_PWRUP: begin
                if (abort_i)               state_d = GRP_UP_ABORT;
                else if (cnt_q == UP_LAST) state_d = GRP_ON;
            end
            GRP_ON:       if (!any_req) state_d = GRP_PWRDN;
            GRP_PWRDN: begin
                if (abort_i || any_req)    state_d = GRP_DN_ABORT;
                else if (cnt_q == DN_LAST) state_d = GRP_OFF;
            end
            GRP_DN_ABORT: state_d = GRP_ON;
            GRP_UP_ABORT: state_d = GRP_OFF;
            default:      state_d = GRP_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GRP_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_d != state_q) begin
            cnt_q <= '0;
        end else if (state_q == GRP_PWRUP || state_q == GRP_PWRDN) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        grp_req_off = 1'b1;
        grp_off     = 1'b1;
        apply_o     = 1'b0;
        unique case (state_q)
            GRP_OFF:      begin grp_req_off = 1'b1; grp_off = 1'b1; end
            GRP_PWRUP:    begin grp_req_off = 1'b0; grp_off = 1'b1; end
            GRP_ON:       begin grp_req_off = 1'b0; grp_off = 1'b0; apply_o = 1'b1; end
            GRP_PWRDN:    begin grp_req_off = 1'b1; grp_off = 1'b0; end
            GRP_DN_ABORT: begin grp_req_off = 1'b0; grp_off = 1'b0; end
            GRP_UP_ABORT: begin grp_req_off = 1'b1; grp_off = 1'b1; end
            default:      begin grp_req_off = 1'b1; grp_off = 1'b1; end
        endcase
    end

endmodule

// File: rtl/gpc_rd_mux.sv
module gpc_rd_mux #(
    parameter int NUM_FRAMES  = 4,
    parameter int FRAME_IDX_W = 2
) (
    input  logic                   rd_hit,
    input  logic [FRAME_IDX_W-1:0] sel,
    input  logic [NUM_FRAMES-1:0]  mode,
    input  logic [NUM_FRAMES-1:0]  frame_on,
    input  logic                   grp_req_off,
    input  logic                   grp_off,
    output logic [31:0]            rdata
);
    import gpc_pkg::*;

    logic sel_mode;
    logic sel_on;

    always_comb begin
        sel_mode = 1'b0;
        sel_on   = 1'b0;
        for (int i = 0; i < NUM_FRAMES; i++) begin
            if (32'(sel) == i) begin
                sel_mode = mode[i];
                sel_on   = frame_on[i];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_hit) begin
            rdata[B_FRM_OFF] = !sel_on;
            rdata[B_MODE]    = sel_mode;
            rdata[B_GRP_TGT] = grp_req_off;
            rdata[B_GRP_OFF] = grp_off;
        end
    end

endmodule

// File: rtl/grp_pwr_gate_ctrl.sv
module grp_pwr_gate_ctrl #(
    parameter int NUM_FRAMES  = 4,
    parameter int UP_CYCLES   = 8,
    parameter int DN_CYCLES   = 8,
    parameter int FRAME_IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_en,
    input  logic                   acc_wr,
    input  logic [FRAME_IDX_W-1:0] acc_frame,
    input  logic [11:0]            acc_offset,
    input  logic [31:0]            acc_wdata,
    output logic [31:0]            acc_rdata,
    input  logic                   grp_abort,
    output logic [NUM_FRAMES-1:0]  frame_pwr_o
);

    logic [NUM_FRAMES-1:0] wr_stb;
    logic                  rd_hit;
    logic [NUM_FRAMES-1:0] want_on;
    logic [NUM_FRAMES-1:0] mode;
    logic [NUM_FRAMES-1:0] frame_on;
    logic                  grp_req_off;
    logic                  grp_off;
    logic                  apply;

    gpc_acc_dec #(.NUM_FRAMES(NUM_FRAMES), .FRAME_IDX_W(FRAME_IDX_W)) u_dec (
        .acc_en     (acc_en),
        .acc_wr     (acc_wr),
        .acc_frame  (acc_frame),
        .acc_offset (acc_offset),
        .wr_stb     (wr_stb),
        .rd_hit     (rd_hit)
    );

    gpc_frame_bank #(.NUM_FRAMES(NUM_FRAMES)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wdata    (acc_wdata),
        .apply    (apply),
        .want_on  (want_on),
        .mode     (mode),
        .frame_on (frame_on)
    );

    gpc_grp_seq #(
        .NUM_FRAMES (NUM_FRAMES),
        .UP_CYCLES  (UP_CYCLES),
        .DN_CYCLES  (DN_CYCLES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .want_on     (want_on),
        .abort_i     (grp_abort),
        .grp_req_off (grp_req_off),
        .grp_off     (grp_off),
        .apply_o     (apply)
    );

    gpc_rd_mux #(.NUM_FRAMES(NUM_FRAMES), .FRAME_IDX_W(FRAME_IDX_W)) u_mux (
        .rd_hit      (rd_hit),
        .sel         (acc_frame),
        .mode        (mode),
        .frame_on    (frame_on),
        .grp_req_off (grp_req_off),
        .grp_off     (grp_off),
        .rdata       (acc_rdata)
    );

    assign frame_pwr_o = frame_on;

endmodule

// File: rtl/grp_pwr_gate_ctrl_chk.sv
module grp_pwr_gate_ctrl_chk #(
    parameter int NUM_FRAMES = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  grp_abort,
    input logic [NUM_FRAMES-1:0] frame_pwr_o,
    input logic                  grp_req_off,
    input logic                  grp_off
);

    // R4: the group only reaches off after targeting off, only reaches on after targeting on
    assert_off_after_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grp_off) |-> $past(grp_req_off));
    assert_on_after_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grp_off) |-> $past(!grp_req_off));

    // R5: no frame is powered while the group is off
    assert_frame_needs_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|frame_pwr_o) |-> !grp_off);

    // R6: a power-down target is only raised with every frame released
    assert_pwrdn_all_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grp_req_off) |-> (frame_pwr_o == '0));

    // R9: an abort during a transition settles the status bits on the next edge
    assert_abort_settles_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_abort && (grp_req_off != grp_off)) |=> (grp_req_off == grp_off));

    // R10: frame outputs change only after a stable-on cycle
    assert_apply_when_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_pwr_o) |-> $past(!grp_off && !grp_req_off));

endmodule

bind grp_pwr_gate_ctrl grp_pwr_gate_ctrl_chk #(.NUM_FRAMES(NUM_FRAMES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .grp_abort   (grp_abort),
    .frame_pwr_o (frame_pwr_o),
    .grp_req_off (grp_req_off),
    .grp_off     (grp_off)
);

// File: tb/grp_pwr_gate_ctrl_tb.sv
module grp_pwr_gate_ctrl_tb;

    localparam int NF  = 4;
    localparam int UPC = 5;
    localparam int DNC = 7;
    localparam logic [11:0] OFS = 12'h024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [1:0]  acc_frame = '0;
    logic [11:0] acc_offset = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        grp_abort = 1'b0;
    logic [NF-1:0] frame_pwr_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #10 clk = ~clk;

    grp_pwr_gate_ctrl #(.NUM_FRAMES(NF), .UP_CYCLES(UPC), .DN_CYCLES(DNC)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_en      (acc_en),
        .acc_wr      (acc_wr),
        .acc_frame   (acc_frame),
        .acc_offset  (acc_offset),
        .acc_wdata   (acc_wdata),
        .acc_rdata   (acc_rdata),
        .grp_abort   (grp_abort),
        .frame_pwr_o (frame_pwr_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc > 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input int f, input logic [11:0] ofs, output logic [31:0] v);
        acc_en = 1'b1; acc_wr = 1'b0; acc_frame = 2'(f); acc_offset = ofs;
        #1;
        v = acc_rdata;
    endtask

    task automatic wr(input int f, input logic [11:0] ofs, input logic [31:0] val);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; acc_frame = 2'(f); acc_offset = ofs; acc_wdata = val;
        @(negedge clk);
        acc_wr = 1'b0;
    endtask

    task automatic abort_pulse();
        grp_abort = 1'b1;
        @(negedge clk);
        grp_abort = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int f = 0; f < NF; f++) begin
            rd(f, OFS, v);
            chk(v == 32'hD, "R1 reset value", v, 32'hD);
        end
        chk(frame_pwr_o == '0, "R1 frame outputs", 32'(frame_pwr_o), 0);
    endtask

    task automatic t_offset();
        logic [31:0] v;
        wr(0, 12'h020, 32'h0);
        repeat (3) @(negedge clk);
        rd(0, OFS, v);
        chk(v == 32'hD, "R2 other-offset write ignored", v, 32'hD);
        chk(frame_pwr_o == '0, "R2 no power from other offset", 32'(frame_pwr_o), 0);
        rd(0, 12'h020, v);
        chk(v == 32'h0, "R2 other-offset read zero", v, 0);
    endtask

    task automatic t_mode();
        logic [31:0] v;
        wr(1, OFS, 32'h2);
        repeat (3) @(negedge clk);
        rd(1, OFS, v);
        chk(v == 32'hF, "R3 mode bit stored, request ignored", v, 32'hF);
        wr(1, OFS, 32'h1);
        @(negedge clk);
        rd(1, OFS, v);
        chk(v == 32'hD, "R3 mode bit cleared", v, 32'hD);
    endtask

    task automatic t_power_up();
        logic [31:0] v;
        int n;
        wr(0, OFS, 32'h0);
        n = 1;
        rd(0, OFS, v);
        chk(v == 32'hD, "R5 not yet started", v, 32'hD);
        @(negedge clk); n++;
        rd(0, OFS, v);
        chk(v == 32'h9, "R5 transit 0/1", v, 32'h9);
        chk(v[2] != v[3], "R4 transit bits differ", v, 32'h9);
        while (v[3] && n < 40) begin
            @(negedge clk); n++;
            rd(0, OFS, v);
        end
        chk(n == UPC + 2, "R5 group-on edge", n, UPC + 2);
        chk(v == 32'h1, "R5 bit0 lags bit3", v, 32'h1);
        @(negedge clk);
        rd(0, OFS, v);
        chk(v == 32'h0, "R5 frame on, R4 stable 0/0", v, 0);
        chk(frame_pwr_o == 4'b0001, "R11 frame output", 32'(frame_pwr_o), 1);
    endtask

    task automatic t_partial_off();
        logic [31:0] v;
        wr(2, OFS, 32'h0);
        @(negedge clk);
        chk(frame_pwr_o == 4'b0101, "R11 second frame on", 32'(frame_pwr_o), 5);
        wr(0, OFS, 32'h1);
        @(negedge clk);
        rd(0, OFS, v);
        chk(v == 32'h1, "R7 non-last off, group stays 0/0", v, 1);
        chk(frame_pwr_o == 4'b0100, "R7 remaining frame", 32'(frame_pwr_o), 4);
    endtask

    task automatic t_last_off();
        logic [31:0] v;
        int n;
        wr(2, OFS, 32'h1);
        n = 1;
        @(negedge clk); n++;
        rd(2, OFS, v);
        chk(v == 32'h5, "R6 target off, bit0 set", v, 5);
        while (!v[3] && n < 40) begin
            @(negedge clk); n++;
            rd(2, OFS, v);
        end
        chk(n == DNC + 2, "R6 group-off edge", n, DNC + 2);
        chk(v == 32'hD, "R6 settled off 1/1", v, 32'hD);
    endtask

    task automatic t_pending();
        logic [31:0] v;
        int n;
        wr(0, OFS, 32'h0);
        @(negedge clk);
        wr(1, OFS, 32'h0);
        wr(0, OFS, 32'h1);
        rd(1, OFS, v);
        chk(v == 32'h9, "R10 held during power-up", v, 32'h9);
        n = 0;
        while (frame_pwr_o != 4'b0010 && n < 30) begin
            @(negedge clk); n++;
        end
        chk(frame_pwr_o == 4'b0010, "R10 held writes applied", 32'(frame_pwr_o), 2);
        rd(0, OFS, v);
        chk(v == 32'h1, "R10 held power-off applied", v, 1);
    endtask

    task automatic t_abort_on();
        logic [31:0] v;
        wr(1, OFS, 32'h1);
        @(negedge clk);
        rd(1, OFS, v);
        chk(v == 32'h5, "R6 power-down started", v, 5);
        @(negedge clk);
        wr(1, OFS, 32'h0);
        rd(1, OFS, v);
        chk(v[3:2] == 2'b01, "R8 still powering down", v, 5);
        @(negedge clk);
        rd(1, OFS, v);
        chk(v == 32'h1, "R8 abort settles 0/0", v, 1);
        @(negedge clk);
        rd(1, OFS, v);
        chk(v == 32'h1, "R8 group on, bit3 stays 0", v, 1);
        @(negedge clk);
        rd(1, OFS, v);
        chk(v == 32'h0, "R8 frame powered", v, 0);
        chk(frame_pwr_o == 4'b0010, "R11 after abort", 32'(frame_pwr_o), 2);
    endtask

    task automatic t_abort_ext_dn();
        logic [31:0] v;
        int n;
        wr(1, OFS, 32'h1);
        @(negedge clk);
        abort_pulse();
        rd(1, OFS, v);
        chk(v == 32'h1, "R9 aborted power-down reads 0/0", v, 1);
        @(negedge clk);
        @(negedge clk);
        rd(1, OFS, v);
        chk(v == 32'h5, "R9 power-down restarts", v, 5);
        n = 0;
        while (!v[3] && n < 40) begin
            @(negedge clk); n++;
            rd(1, OFS, v);
        end
        chk(v == 32'hD, "R9 eventually off", v, 32'hD);
    endtask

    task automatic t_abort_ext_up();
        logic [31:0] v;
        int n;
        wr(3, OFS, 32'h0);
        @(negedge clk);
        rd(3, OFS, v);
        chk(v == 32'h9, "R5 power-up running", v, 9);
        abort_pulse();
        rd(3, OFS, v);
        chk(v == 32'hD, "R9 aborted power-up reads 1/1", v, 32'hD);
        @(negedge clk);
        rd(3, OFS, v);
        chk(v == 32'hD, "R9 settled off", v, 32'hD);
        @(negedge clk);
        rd(3, OFS, v);
        chk(v == 32'h9, "R9 power-up retried", v, 9);
        n = 0;
        while (v != 32'h0 && n < 40) begin
            @(negedge clk); n++;
            rd(3, OFS, v);
        end
        chk(v == 32'h0, "R9 frame finally on", v, 0);
        chk(frame_pwr_o == 4'b1000, "R11 after retry", 32'(frame_pwr_o), 8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_offset();
        t_mode();
        t_power_up();
        t_partial_off();
        t_last_off();
        t_pending();
        t_abort_on();
        t_abort_ext_dn();
        t_abort_ext_up();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule